// File: doc/BRIEF.md
# Octant Tangent Coil Drive Encoder

This block turns a 10-bit pointer angle into the two signed drive values needed by a two-coil (quadrature) air-core meter. The angle circle is split into 1024 equal steps. The three upper bits pick one of eight 45° sectors, and the seven lower bits pick a step inside that sector. In every sector, one coil is pinned at full scale (128) with a sign that is fixed for that sector. The other coil follows a tangent-shaped ramp, so only one coil value changes while the angle moves through a sector.

A host presents a code together with a one-cycle load strobe. The block latches the code, and the two drive values follow from the latched code on the next cycle. An enable input forces both drive values to zero without losing the latched angle. Each drive value is a negative flag plus an 8-bit magnitude. Analog conversion and scaling happen downstream.

Top module: `gauge_coil_encoder`

## Requirements
- R1: After reset the latched angle is code 0, so with enable high the outputs show cosine positive at magnitude 128 and sine positive at magnitude 0.
- R2: A code is captured at a rising clock edge where `load_i` is high, and the outputs reflect it right after that edge. While `load_i` is low, changes on `code_i` leave all four outputs unchanged.
- R3: Code bits 9..7 form the sector number s (0..7) and bits 6..0 form the in-sector step n (0..127). Code 128·k therefore lands on the first step of sector k.
- R4: In each sector exactly one coil has magnitude 128. The cosine coil is held in sectors 0, 3, 4 and 7, and the sine coil is held in sectors 1, 2, 5 and 6.
- R5: The negative flags by sector, written as (sine, cosine), are: 0:(0,0), 1:(0,0), 2:(0,1), 3:(0,1), 4:(1,1), 5:(1,1), 6:(1,0), 7:(1,0). The flags apply whether or not the magnitude is zero.
- R6: In even sectors the ramp magnitude is T(n) = round(128·tan((n+0.5)·45°/128)). This ramp rises with n, from 0 at n=0 to 127 at n=127.
- R7: In odd sectors the ramp magnitude is T(127−n), so it falls as the code rises.
- R8: The ramp magnitude is always below 128, so the held coil is the only coil at full scale.
- R9: While `enable_i` is low, both magnitudes and both negative flags are 0. The latched angle is kept, and it reappears when `enable_i` returns high, without a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe that captures `code_i` |
| code_i | input | 10 | Angle code: sector in 9..7, step in 6..0 |
| enable_i | input | 1 | High passes the drive values; low forces them to zero |
| sin_neg_o | output | 1 | Sine coil negative flag |
| sin_mag_o | output | 8 | Sine coil magnitude, 0..128 |
| cos_neg_o | output | 1 | Cosine coil negative flag |
| cos_mag_o | output | 8 | Cosine coil magnitude, 0..128 |

## Verification
The bench builds the block with its default code width of 10, which leaves a 7-bit step field and a 128-entry tangent table. At this size every one of the 1024 codes can be loaded and compared against a sine-over-cosine model in a few thousand cycles. That sweep reaches every sector transition, both ends of each ramp and every table entry in both the rising and the mirrored order. Separate scenarios cover load-less code changes and an enable drop with recovery.

// File: rtl/gauge_pkg.sv
package gauge_pkg;

  localparam int OCT_W = 3;

  typedef struct packed {
    logic sin_held;   // sine coil pinned at full scale
    logic sin_neg;
    logic cos_neg;
    logic reverse;    // ramp falls with the code
  } oct_plan_t;

  // Sector decode: odd sectors mirror the ramp, held coil alternates in pairs.
  function automatic oct_plan_t oct_plan(input logic [OCT_W-1:0] s);
    oct_plan_t p;
    p.reverse  = s[0];
    p.sin_held = s[0] ^ s[1];
    p.sin_neg  = s[2];
    p.cos_neg  = s[2] ^ s[1];
    return p;
  endfunction

endpackage

// File: rtl/gauge_tan_rom.sv
module gauge_tan_rom #(
  parameter int FRAC_W = 7
) (
  input  logic [FRAC_W-1:0] idx_i,
  output logic [FRAC_W:0]   mag_o
);

  localparam int  DEPTH   = 1 << FRAC_W;
  localparam int  MAG_W   = FRAC_W + 1;
  localparam real QUART_PI = 0.7853981633974483;

  logic [MAG_W-1:0] table_w [DEPTH];

  // Entries computed at elaboration: round(full * tan((i + 0.5) * 45deg / DEPTH)).
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam real ANG = (real'(i) + 0.5) * QUART_PI / real'(DEPTH);
    localparam int  VAL = int'($floor(real'(DEPTH) * $tan(ANG) + 0.5));
    assign table_w[i] = MAG_W'(VAL);
  end

  assign mag_o = table_w[idx_i];

  // Rounding must never push a ramp entry up to full scale.
  always_comb begin
    if (!$isunknown(idx_i)) begin
      assert_ramp_below_full_R8: assert (mag_o < MAG_W'(DEPTH))
        else $error("ramp entry reached full scale");
    end
  end

endmodule

// File: rtl/gauge_octant_map.sv
module gauge_octant_map
  import gauge_pkg::*;
#(
  parameter int FRAC_W = 7
) (
  input  logic [OCT_W-1:0]  oct_i,
  input  logic [FRAC_W-1:0] step_i,
  input  logic [FRAC_W:0]   ramp_mag_i,
  output logic [FRAC_W-1:0] rom_idx_o,
  output logic              sin_neg_o,
  output logic [FRAC_W:0]   sin_mag_o,
  output logic              cos_neg_o,
  output logic [FRAC_W:0]   cos_mag_o
);

  localparam int MAG_W = FRAC_W + 1;
  localparam logic [MAG_W-1:0] FULL_MAG = MAG_W'(1) << FRAC_W;

  oct_plan_t plan;
  assign plan = oct_plan(oct_i);

  // Mirrored index for falling sectors: bitwise inverse equals (DEPTH-1) - step.
  assign rom_idx_o = plan.reverse ? ~step_i : step_i;

  always_comb begin
    if (plan.sin_held) begin
      sin_mag_o = FULL_MAG;
      cos_mag_o = ramp_mag_i;
    end else begin
      sin_mag_o = ramp_mag_i;
      cos_mag_o = FULL_MAG;
    end
    sin_neg_o = plan.sin_neg;
    cos_neg_o = plan.cos_neg;
  end

endmodule

// File: rtl/gauge_coil_encoder.sv
module gauge_coil_encoder
  import gauge_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic                     enable_i,
  output logic                     sin_neg_o,
  output logic [CODE_W-OCT_W:0]    sin_mag_o,
  output logic                     cos_neg_o,
  output logic [CODE_W-OCT_W:0]    cos_mag_o
);

  localparam int FRAC_W = CODE_W - OCT_W;
  localparam int MAG_W  = FRAC_W + 1;
  localparam logic [MAG_W-1:0] FULL_MAG = MAG_W'(1) << FRAC_W;

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (load_i) code_q <= code_i;
  end

  // Named internal events for the assertions.
  logic [OCT_W-1:0]  oct_w;
  logic [FRAC_W-1:0] step_w;
  logic [FRAC_W-1:0] rom_idx_w;
  logic [MAG_W-1:0]  ramp_mag_w;
  logic              sin_neg_w, cos_neg_w;
  logic [MAG_W-1:0]  sin_mag_w, cos_mag_w;

  assign oct_w  = code_q[CODE_W-1 -: OCT_W];
  assign step_w = code_q[FRAC_W-1:0];

  gauge_tan_rom #(.FRAC_W(FRAC_W)) u_rom (
    .idx_i (rom_idx_w),
    .mag_o (ramp_mag_w)
  );

  gauge_octant_map #(.FRAC_W(FRAC_W)) u_map (
    .oct_i      (oct_w),
    .step_i     (step_w),
    .ramp_mag_i (ramp_mag_w),
    .rom_idx_o  (rom_idx_w),
    .sin_neg_o  (sin_neg_w),
    .sin_mag_o  (sin_mag_w),
    .cos_neg_o  (cos_neg_w),
    .cos_mag_o  (cos_mag_w)
  );

  always_comb begin
    if (enable_i) begin
      sin_neg_o = sin_neg_w;
      sin_mag_o = sin_mag_w;
      cos_neg_o = cos_neg_w;
      cos_mag_o = cos_mag_w;
    end else begin
      sin_neg_o = 1'b0;
      sin_mag_o = '0;
      cos_neg_o = 1'b0;
      cos_mag_o = '0;
    end
  end

  // Exactly one coil at full scale whenever outputs are live.
  assert_one_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i |-> ($countones({sin_mag_o == FULL_MAG, cos_mag_o == FULL_MAG}) == 1));

  // Without a strobe the live outputs keep their value.
  assert_hold_without_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_i) && enable_i && $past(enable_i))
      |-> $stable({sin_neg_o, sin_mag_o, cos_neg_o, cos_mag_o}));

  // Disabled outputs read as zero drive.
  assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> (sin_mag_o == '0 && cos_mag_o == '0 && !sin_neg_o && !cos_neg_o));

  // Re-enabling restores the latched angle: the held coil is full again.
  assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable_i) |-> (sin_mag_o == FULL_MAG || cos_mag_o == FULL_MAG));

endmodule

// File: tb/gauge_coil_encoder_bench.sv
module gauge_coil_encoder_bench;

  localparam int  CLK_P  = 10;
  localparam real Q_STEP = 3.141592653589793 / 512.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [9:0] code_i = '0;
  logic       enable_i = 1'b1;
  logic       sin_neg_o, cos_neg_o;
  logic [7:0] sin_mag_o, cos_mag_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gauge_coil_encoder u_gauge_coil_encoder (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .code_i(code_i),
    .enable_i(enable_i), .sin_neg_o(sin_neg_o), .sin_mag_o(sin_mag_o),
    .cos_neg_o(cos_neg_o), .cos_mag_o(cos_mag_o)
  );

  // Tangent of the half-step centred angle, written as sine over cosine.
  function automatic int ramp_of(input int k);
    real a;
    a = (real'(k) + 0.5) * Q_STEP;
    return $rtoi($floor(128.0 * $sin(a) / $cos(a) + 0.5));
  endfunction

  // Expected {sin_neg, sin_mag, cos_neg, cos_mag} per sector table.
  function automatic logic [17:0] expect_of(input int c);
    int s, n, t;
    logic [17:0] e;
    s = c / 128;
    n = c % 128;
    t = (s % 2 == 0) ? ramp_of(n) : ramp_of(127 - n);
    case (s)
      0: e = {1'b0, 8'(t),   1'b0, 8'd128};
      1: e = {1'b0, 8'd128, 1'b0, 8'(t)};
      2: e = {1'b0, 8'd128, 1'b1, 8'(t)};
      3: e = {1'b0, 8'(t),   1'b1, 8'd128};
      4: e = {1'b1, 8'(t),   1'b1, 8'd128};
      5: e = {1'b1, 8'd128, 1'b1, 8'(t)};
      6: e = {1'b1, 8'd128, 1'b0, 8'(t)};
      default: e = {1'b1, 8'(t), 1'b0, 8'd128};
    endcase
    return e;
  endfunction

  task automatic check(input string req, input logic [17:0] exp_v);
    logic [17:0] act;
    act = {sin_neg_o, sin_mag_o, cos_neg_o, cos_mag_o};
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual sn=%0d sm=%0d cn=%0d cm=%0d expected sn=%0d sm=%0d cn=%0d cm=%0d",
               req, act[17], act[16:9], act[8], act[7:0],
               exp_v[17], exp_v[16:9], exp_v[8], exp_v[7:0]);
    end
  endtask

  task automatic load_code(input int c);
    @(negedge clk);
    code_i = 10'(c);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic t_reset;
    // R1: code 0 after reset
    check("R1", {1'b0, 8'd0, 1'b0, 8'd128});
  endtask

  task automatic t_boundaries;
    // R3 R4 R5: first step of each sector
    for (int k = 0; k < 8; k++) begin
      load_code(128 * k);
      check("R3", expect_of(128 * k));
    end
    load_code(0);
    check("R6", {1'b0, 8'd0, 1'b0, 8'd128});
    load_code(127);
    check("R6", {1'b0, 8'd127, 1'b0, 8'd128});
    load_code(128);
    check("R7", {1'b0, 8'd128, 1'b0, 8'd127});
    load_code(255);
    check("R7", {1'b0, 8'd128, 1'b0, 8'd0});
  endtask

  task automatic t_sweep;
    // R4 R5 R6 R7 R8 over every code
    for (int c = 0; c < 1024; c++) begin
      load_code(c);
      if ((c / 128) % 2 == 0) check("R6", expect_of(c));
      else                    check("R7", expect_of(c));
      checks++;
      if (sin_mag_o == 8'd128 && cos_mag_o == 8'd128) begin
        fails++;
        $display("FAIL R8: code %0d actual both magnitudes 128 expected one", c);
      end
    end
  endtask

  task automatic t_hold;
    // R2: code changes without a strobe are ignored
    load_code(700);
    @(negedge clk);
    code_i = 10'd300;
    repeat (3) @(negedge clk);
    check("R2", expect_of(700));
    code_i = 10'd5;
    @(negedge clk);
    check("R2", expect_of(700));
  endtask

  task automatic t_enable;
    // R9: gating to zero and recovery of the latched angle
    load_code(900);
    enable_i = 1'b0;
    #1;
    check("R9", 18'd0);
    load_code(600);
    check("R9", 18'd0);
    @(negedge clk);
    enable_i = 1'b1;
    #1;
    check("R9", expect_of(600));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boundaries();
    t_hold();
    t_enable();
    t_sweep();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule